// File: doc/BRIEF.md
# Dual-Compare Timer with Half-Cycle Output

This block is a 16-bit up-counter with two compare registers. It drives one output pin with a PWM or clock-like waveform and raises two single-cycle interrupt strobes. Compare A sets the count at which the output turns active. Compare B sets the count at which the counter wraps back to zero and the output returns to its inactive level. A polarity bit chooses whether active means high or low. While a run enable is high the counter advances once per rising edge of the input clock. A synchronous clear restarts the period at any time.

In fine mode the low bit of compare A becomes a half-cycle selector. The upper fifteen bits of compare A are compared with the lower fifteen counter bits. When the low bit is set, the active transition is moved onto the following falling clock edge by a falling-edge stage. This lets the duty be tuned in half-cycle steps and halves the usable count range.

The controlling logic is a two-state phase machine. In state WAIT the output is inactive and the machine is waiting for compare A. In state ACTIVE the output is active and the machine is waiting for compare B. The transitions are:
- A-hit moves WAIT to ACTIVE.
- Wrap moves ACTIVE to WAIT.
- Wrap in WAIT stays in WAIT, which happens when compare A can never be reached.
- Clear forces WAIT from either state.

Top module: `dct_timer`

## Requirements
- R1: While run is high the counter advances by one per rising edge. At the edge where the count is greater than or equal to compare B it returns to 0 instead. irq_b is high for exactly the cycle after that edge, so with B=5 the count runs 0,1,2,3,4,5,0 with irq_b high while the count is 0.
- R2: The output is inactive until the rising edge at which the count equals compare A. From the cycle after that edge it is active, and irq_a is high for that one cycle. The output stays active until the wrap edge, so it is active for B-A cycles per period. A=0 with B=1 gives half the input clock frequency.
- R3: Control bit 0 is the polarity. With 0 the active level is 1 and the inactive level is 0. With 1 both levels are inverted.
- R4: Control bit 1 enables fine mode. In fine mode, compare A bits [15:1] are compared with counter bits [14:0]. With compare A bit 0 equal to 0, the active transition stays on the rising edge. For example, fine mode with A=4 gives the same waveform as normal mode with A=2.
- R5: In fine mode with compare A bit 0 equal to 1, the active transition happens on the falling edge half a cycle after the rising edge it would otherwise use. The return to inactive stays on the rising edge. A=2B-1 therefore gives a single half-cycle pulse.
- R6: Fine mode is off after reset. In fine mode, compare A equal to 0 gives the same waveform as in normal mode.
- R7: If the effective compare A is greater than or equal to compare B, irq_a never fires and the output stays at the inactive level, while irq_b still fires at each wrap. When compare A equals compare B, the wrap takes priority.
- R8: While run is low the count and the phase hold and neither interrupt fires. When run returns high, counting resumes from the held count.
- R9: A clear sampled at a rising edge sets the count to 0, makes the output inactive and suppresses both interrupts in the next cycle. Clear overrides run. Counting restarts from 0 afterwards.
- R10: After reset the output is 0, both interrupts are 0, and both compare registers and the control bits are 0.
- R11: The write port stores wr_data at the rising edge where wr_en is high. Address 0 selects compare A, address 1 selects compare B, and address 2 selects control (bit 0 polarity, bit 1 fine mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; counting on the rising edge, half-cycle stage on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of count and phase |
| run | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare A, 1 compare B, 2 control |
| wr_data | input | 16 | Write data |
| tmr_out | output | 1 | Timer output pin |
| irq_a | output | 1 | Compare A interrupt strobe |
| irq_b | output | 1 | Compare B (wrap) interrupt strobe |

## Verification
The compare-A hit and the compare-B wrap can land on the same rising edge. This is provoked by programming A equal to B. Each such run is judged half-cycle by half-cycle against a model built from the requirements: the wrap must win, irq_b must pulse, irq_a must stay low and the output must stay inactive for the whole run. The same model covers a fine-mode A of 2B-1, where the A hit lands one count before the wrap. In that case the output must be active only during the falling-edge half of the final count.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int ADDR_W    = 2;
    localparam int CTRL_POL  = 0;
    localparam int CTRL_FINE = 1;

    localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

    typedef enum logic {
        PH_WAIT   = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_t;
endpackage

// File: rtl/dct_regs.sv
module dct_regs
    import dct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      cmp_a,
    output logic [W-1:0]      cmp_b,
    output logic              pol,
    output logic              fine
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_a <= '0;
            cmp_b <= '0;
            pol   <= 1'b0;
            fine  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CMPA: cmp_a <= wr_data;
                ADDR_CMPB: cmp_b <= wr_data;
                ADDR_CTRL: begin
                    pol  <= wr_data[CTRL_POL];
                    fine <= wr_data[CTRL_FINE];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         fine,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    output logic [W-1:0] cnt,
    output logic         hit_a,
    output logic         hit_b
);
    localparam int HW = W - 1;

    logic eq_full;
    logic eq_fine;

    assign eq_full = (cnt == cmp_a);
    assign eq_fine = (cnt[HW-1:0] == cmp_a[W-1:1]);

    // wrap wins over a compare A hit on the same count
    assign hit_b = run && (cnt >= cmp_b);
    assign hit_a = run && !hit_b && (fine ? eq_fine : eq_full);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || hit_b) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dct_phase_fsm.sv
module dct_phase_fsm
    import dct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit_a,
    input  logic hit_b,
    output logic act,
    output logic irq_a,
    output logic irq_b
);
    phase_t state;
    phase_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_WAIT:   if (hit_a) state_nx = PH_ACTIVE;
            PH_ACTIVE: if (hit_b) state_nx = PH_WAIT;
        endcase
        if (clr) state_nx = PH_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_WAIT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_a <= 1'b0;
            irq_b <= 1'b0;
        end else begin
            irq_a <= !clr && (state == PH_WAIT) && hit_a;
            irq_b <= !clr && hit_b;
        end
    end

    assign act = (state == PH_ACTIVE);
endmodule

// File: rtl/dct_edge_out.sv
module dct_edge_out (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic half,
    input  logic pol,
    output logic tmr_out
);
    logic act_neg;
    logic lvl;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) act_neg <= 1'b0;
        else        act_neg <= act;
    end

    // delayed rise, immediate fall when the half-cycle offset is selected
    assign lvl     = half ? (act && act_neg) : act;
    assign tmr_out = lvl ^ pol;
endmodule

// File: rtl/dct_timer.sv
module dct_timer
    import dct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              tmr_out,
    output logic              irq_a,
    output logic              irq_b
);
    logic [W-1:0] cmp_a;
    logic [W-1:0] cmp_b;
    logic [W-1:0] cnt_q;
    logic         pol;
    logic         fine;
    logic         hit_a;
    logic         hit_b;
    logic         act;
    logic         half;

    dct_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .pol     (pol),
        .fine    (fine)
    );

    dct_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .run   (run),
        .fine  (fine),
        .cmp_a (cmp_a),
        .cmp_b (cmp_b),
        .cnt   (cnt_q),
        .hit_a (hit_a),
        .hit_b (hit_b)
    );

    dct_phase_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit_a (hit_a),
        .hit_b (hit_b),
        .act   (act),
        .irq_a (irq_a),
        .irq_b (irq_b)
    );

    assign half = fine && cmp_a[0];

    dct_edge_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .half    (half),
        .pol     (pol),
        .tmr_out (tmr_out)
    );
endmodule

// File: rtl/dct_timer_chk.sv
module dct_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         run,
    input logic [W-1:0] cnt,
    input logic         act,
    input logic         irq_a,
    input logic         irq_b
);
    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> (cnt == '0));

    a_r2_irq_with_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> act);

    a_r2_rise_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> irq_a);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(cnt) && $stable(act) && !irq_a && !irq_b));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((cnt == '0) && !act && !irq_a && !irq_b));
endmodule

bind dct_timer dct_timer_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .run   (run),
    .cnt   (cnt_q),
    .act   (act),
    .irq_a (irq_a),
    .irq_b (irq_b)
);

// File: tb/dct_timer_bench.sv
`timescale 1ns/1ps
module dct_timer_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         run = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         tmr_out;
    logic         irq_a;
    logic         irq_b;

    int checks = 0;
    int fails  = 0;
    bit armed  = 1'b0;

    typedef struct {
        logic [2:0] v;
        string      tag;
        int         k;
        bit         low;
    } item_t;

    item_t q[$];

    always #5 clk = ~clk;

    dct_timer #(.W(W)) u_dct_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .run     (run),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tmr_out (tmr_out),
        .irq_a   (irq_a),
        .irq_b   (irq_b)
    );

    task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {out,irq_a,irq_b} actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic wr(logic [1:0] addr, logic [W-1:0] data);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic clear_pulse();
        @(negedge clk); #1;
        clr = 1'b1;
        @(negedge clk); #1;
        clr = 1'b0;
    endtask

    // driver: programs a setting, pushes the expected half-cycle samples, then runs
    task automatic run_case(string tag, int a, int b, bit pol, bit fine, bit do_ctrl, int n);
        int  ae;
        bit  valid, half, prev, actv, ia, ib, hi, lo;
        int  c;
        wr(2'd0, W'(a));
        wr(2'd1, W'(b));
        if (do_ctrl) wr(2'd2, W'({fine, pol}));
        clear_pulse();
        ae    = fine ? (a >> 1) : a;
        valid = (ae < b);
        half  = fine && a[0];
        prev  = 1'b0;
        for (int k = 1; k <= n; k++) begin
            c    = k % (b + 1);
            actv = valid && (c > ae);
            ia   = valid && (c == ae + 1);
            ib   = (c == 0);
            hi   = half ? (actv && prev) : actv;
            lo   = actv;
            q.push_back('{v: {hi ^ pol, ia, ib}, tag: tag, k: k, low: 1'b0});
            q.push_back('{v: {lo ^ pol, ia, ib}, tag: tag, k: k, low: 1'b1});
            prev = actv;
        end
        @(negedge clk); #3;
        armed = 1'b1; run = 1'b1;
        repeat (n) @(negedge clk);
        #3;
        armed = 1'b0; run = 1'b0;
        if (q.size() != 0) chk({tag, " queue drained"}, 3'(q.size()), 3'd0);
    endtask

    // monitor: one sample in each clock phase while armed
    initial begin
        item_t it;
        forever begin
            @(posedge clk); #2;
            if (armed && q.size() > 0) begin
                it = q.pop_front();
                chk($sformatf("%s k=%0d high", it.tag, it.k), {tmr_out, irq_a, irq_b}, it.v);
            end
            @(negedge clk); #2;
            if (armed && q.size() > 0) begin
                it = q.pop_front();
                chk($sformatf("%s k=%0d low", it.tag, it.k), {tmr_out, irq_a, irq_b}, it.v);
            end
        end
    end

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R10 reset state", {tmr_out, irq_a, irq_b}, 3'b000);

        // fine mode left at its reset value (R6), written registers (R11)
        run_case("R2,R6,R11 normal A=3 B=5", 3, 5, 1'b0, 1'b0, 1'b0, 14);
        run_case("R3 normal A=3 B=5 inverted", 3, 5, 1'b1, 1'b0, 1'b1, 14);
        run_case("R5 fine A=3 B=5", 3, 5, 1'b0, 1'b1, 1'b1, 14);
        run_case("R3,R5 fine A=3 B=5 inverted", 3, 5, 1'b1, 1'b1, 1'b1, 14);
        run_case("R2,R1 normal A=0 B=1 half rate", 0, 1, 1'b0, 1'b0, 1'b1, 8);
        run_case("R6 fine A=0 B=1", 0, 1, 1'b0, 1'b1, 1'b1, 8);
        run_case("R4 fine A=4 B=5", 4, 5, 1'b0, 1'b1, 1'b1, 14);
        run_case("R5 fine A=9 B=5 top of range", 9, 5, 1'b0, 1'b1, 1'b1, 14);
        run_case("R7 normal A=6 B=5", 6, 5, 1'b0, 1'b0, 1'b1, 14);
        run_case("R7 normal A=5 B=5 same cycle", 5, 5, 1'b0, 1'b0, 1'b1, 14);
        run_case("R1 normal A=2 B=7", 2, 7, 1'b0, 1'b0, 1'b1, 18);

        // R8: stop while active, hold, resume
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd0);
        clear_pulse();
        @(negedge clk); #3;
        run = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #3;
        run = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #2;
            chk("R8 hold while stopped", {tmr_out, irq_a, irq_b}, 3'b100);
        end
        @(negedge clk); #3;
        run = 1'b1;
        repeat (2) @(posedge clk); #2;
        chk("R8 resumed count 5", {tmr_out, irq_a, irq_b}, 3'b100);
        @(posedge clk); #2;
        chk("R8 resumed wrap", {tmr_out, irq_a, irq_b}, 3'b001);
        @(negedge clk); #3;
        run = 1'b0;

        // R9: clear while active and running
        clear_pulse();
        @(negedge clk); #3;
        run = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk); #3;
        clr = 1'b1;
        @(posedge clk); #2;
        chk("R9 clear forces inactive", {tmr_out, irq_a, irq_b}, 3'b000);
        @(negedge clk); #3;
        clr = 1'b0;
        @(posedge clk); #2;
        chk("R9 restart count 1", {tmr_out, irq_a, irq_b}, 3'b000);
        @(posedge clk); #2;
        chk("R9 restart reaches A", {tmr_out, irq_a, irq_b}, 3'b110);
        @(negedge clk); #3;
        run = 1'b0;

        repeat (2) @(posedge clk);
        report();
        $finish;
    end
endmodule